// File: doc/BRIEF.md
# Receive Sample Interleaver and Packer

This block sits between the decimating receive path and the host link FIFO. Four real converter inputs arrive together on one sample strobe. A routing stage assigns a converter input to each of four components: channel 0 I, channel 0 Q, channel 1 I and channel 1 Q. Any component can be left unconnected, and it then reads as zero. The routed components of the active channels are interleaved into a single 16-bit word stream. That stream leaves through a valid/ready handshake.

Two packing modes are selectable at run time. In full-width mode every component takes a whole 16-bit word. In narrow mode each component is cut to its upper byte, and two components share one word. This halves the link traffic per sample, at the cost of dynamic range. A single-channel setting emits only channel 0.

Mode and channel count are latched when a sample group is captured, so a group never mixes packings. A strobe that arrives while the previous group is still leaving is dropped. It raises a sticky overrun flag, which only an explicit clear input resets.

Top module: `rx_sample_packer`

## Requirements
- R1: After synchronous reset, word_valid and ovr_flag are both 0.
- R2: Each component has a 3-bit field in route_sel: bits [2:0] channel 0 I, [5:3] channel 0 Q, [8:6] channel 1 I, [11:9] channel 1 Q. A field value k from 0 to 3 routes adc_data[16k+15:16k]. Values 4 to 7 leave the component unconnected, and it then reads as zero.
- R3: In full-width mode (narrow_en=0) with dual_en=0, a group yields two words in the order channel 0 I, then channel 0 Q.
- R4: In full-width mode with dual_en=1, a group yields four words in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q.
- R5: In narrow mode (narrow_en=1), each component is reduced to its bits [15:8]. Each word holds the earlier component in bits [7:0] and the later one in bits [15:8]. A group yields one word {ch0 Q, ch0 I} for a single channel, and a second word {ch1 Q, ch1 I} when dual_en=1.
- R6: While word_valid=1 and word_ready=0, word_valid stays 1 and word_data stays unchanged. A word is consumed only in a cycle where both are 1.
- R7: A smp_valid pulse that arrives while words of the previous group are still pending is dropped, except in the cycle where the final word is consumed. The dropped pulse produces no words and sets ovr_flag on the next cycle. ovr_flag then stays 1.
- R8: ovr_clr=1 clears ovr_flag on the next cycle. If an overrun occurs in the same cycle, the flag is set and the clear is lost.
- R9: narrow_en and dual_en are sampled only in the capture cycle. Changing them while a group is pending does not alter that group's words.
- R10: A smp_valid pulse in the same cycle that the final word of a group is consumed is captured without an overrun. Its first word is presented in the next cycle, so the output has no idle gap.
- R11: A captured group presents its first word with word_valid=1 in the cycle right after the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 64 | Four 16-bit converter samples; input k in bits [16k+15:16k] |
| smp_valid | input | 1 | One-cycle strobe marking a new sample group |
| route_sel | input | 12 | Four 3-bit routing fields, one per component |
| dual_en | input | 1 | 1: both complex channels active; 0: channel 0 only |
| narrow_en | input | 1 | 1: 8-bit component packing; 0: 16-bit components |
| word_data | output | 16 | Output word |
| word_valid | output | 1 | Output word is valid |
| word_ready | input | 1 | Consumer accepts the word |
| ovr_flag | output | 1 | Sticky overrun indication |
| ovr_clr | input | 1 | Clears ovr_flag |

## Verification
Two situations can fall in the same cycle. The first is a new sample strobe arriving as the final word of a group is consumed. The bench chains groups of one, two and four words, with ready held high and each strobe timed onto the final handshake. It then checks that the scoreboard sees every word in order, with no idle cycle and no overrun. The second is an overrun colliding with a flag clear. The bench drives a dropped strobe and ovr_clr together while the output is stalled, and expects the flag to stay set.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    parameter int SMP_W  = 16;
    parameter int N_ADC  = 4;
    parameter int N_CH   = 2;
    localparam int N_COMP = 2 * N_CH;
    localparam int HALF_W = SMP_W / 2;
    localparam int SEL_W  = $clog2(N_ADC) + 1;
    localparam int CNT_W  = $clog2(N_COMP + 1);

    typedef logic [SMP_W-1:0] comp_t;
    typedef comp_t [N_COMP-1:0] comp_vec_t;

    typedef enum logic {
        PACK_WIDE   = 1'b0,
        PACK_NARROW = 1'b1
    } pack_mode_e;

    typedef struct packed {
        comp_vec_t        words;
        logic [CNT_W-1:0] count;
    } group_t;

    function automatic logic [HALF_W-1:0] upper_half(comp_t c);
        return c[SMP_W-1:HALF_W];
    endfunction

    function automatic comp_t pair_pack(comp_t early, comp_t late);
        return {upper_half(late), upper_half(early)};
    endfunction
endpackage

// File: rtl/rxp_router.sv
module rxp_router
    import rxp_pkg::*;
(
    input  logic [N_ADC*SMP_W-1:0]  adc_flat,
    input  logic [N_COMP*SEL_W-1:0] sel_flat,
    output comp_vec_t               comps
);
    // R2: one selector per component; out-of-range codes read as zero
    for (genvar g = 0; g < N_COMP; g++) begin : g_comp
        comp_t pick;
        always_comb begin
            pick = '0;
            for (int k = 0; k < N_ADC; k++) begin
                if (sel_flat[g*SEL_W +: SEL_W] == SEL_W'(k))
                    pick = adc_flat[k*SMP_W +: SMP_W];
            end
        end
        assign comps[g] = pick;
    end
endmodule

// File: rtl/rxp_group_builder.sv
module rxp_group_builder
    import rxp_pkg::*;
(
    input  comp_vec_t  comps,
    input  logic       dual_en,
    input  pack_mode_e mode,
    output group_t     grp
);
    comp_t narrow_w [N_CH];

    // R5: earlier component of each pair goes to the low byte
    for (genvar p = 0; p < N_CH; p++) begin : g_pair
        assign narrow_w[p] = pair_pack(comps[2*p], comps[2*p+1]);
    end

    always_comb begin
        grp = '0;
        if (mode == PACK_NARROW) begin
            for (int p = 0; p < N_CH; p++) grp.words[p] = narrow_w[p];
            grp.count = dual_en ? CNT_W'(N_CH) : CNT_W'(1);
        end else begin
            grp.words = comps;
            grp.count = dual_en ? CNT_W'(N_COMP) : CNT_W'(2);
        end
    end
endmodule

// File: rtl/rxp_word_sequencer.sv
module rxp_word_sequencer
    import rxp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_valid,
    input  group_t grp_in,
    input  logic   word_ready,
    input  logic   ovr_clr,
    output comp_t  word_data,
    output logic   word_valid,
    output logic   ovr_flag
);
    group_t           held;
    logic [CNT_W-1:0] idx;
    logic             busy;
    logic             fire;
    logic             last;
    logic             accept;
    logic             drop;

    assign fire   = busy && word_ready;
    assign last   = (idx == held.count - CNT_W'(1));
    assign accept = smp_valid && (!busy || (fire && last));
    assign drop   = smp_valid && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            idx  <= '0;
            busy <= 1'b0;
        end else if (accept) begin
            held <= grp_in;
            idx  <= '0;
            busy <= 1'b1;
        end else if (fire) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             ovr_flag <= 1'b0;
        else if (drop)       ovr_flag <= 1'b1;
        else if (ovr_clr)    ovr_flag <= 1'b0;
    end

    assign word_valid = busy;
    assign word_data  = held.words[idx[$clog2(N_COMP)-1:0]];

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid && !word_ready |=> word_valid && $stable(word_data));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid && word_valid && !(word_ready && last) |=> ovr_flag);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_flag && !ovr_clr |=> ovr_flag);

    // R11
    first_word_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !word_valid |=> word_valid);
endmodule

// File: rtl/rx_sample_packer.sv
module rx_sample_packer
    import rxp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_ADC*SMP_W-1:0]  adc_data,
    input  logic                    smp_valid,
    input  logic [N_COMP*SEL_W-1:0] route_sel,
    input  logic                    dual_en,
    input  logic                    narrow_en,
    output logic [SMP_W-1:0]        word_data,
    output logic                    word_valid,
    input  logic                    word_ready,
    output logic                    ovr_flag,
    input  logic                    ovr_clr
);
    comp_vec_t  comps;
    group_t     grp;
    pack_mode_e mode;

    assign mode = narrow_en ? PACK_NARROW : PACK_WIDE;

    rxp_router u_router (
        .adc_flat (adc_data),
        .sel_flat (route_sel),
        .comps    (comps)
    );

    rxp_group_builder u_build (
        .comps   (comps),
        .dual_en (dual_en),
        .mode    (mode),
        .grp     (grp)
    );

    rxp_word_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .grp_in     (grp),
        .word_ready (word_ready),
        .ovr_clr    (ovr_clr),
        .word_data  (word_data),
        .word_valid (word_valid),
        .ovr_flag   (ovr_flag)
    );
endmodule

// File: tb/tb_rx_sample_packer.sv
module tb_rx_sample_packer;
    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] adc_data = '0;
    logic        smp_valid = 0;
    logic [11:0] route_sel = '0;
    logic        dual_en = 0;
    logic        narrow_en = 0;
    logic [15:0] word_data;
    logic        word_valid;
    logic        word_ready = 0;
    logic        ovr_flag;
    logic        ovr_clr = 0;

    int checks = 0;
    int errors = 0;
    int gaps = 0;
    int rdy_mode = 0;
    int cyc = 0;
    bit watch = 0;
    bit hold_pend = 0;
    logic [15:0] held_w;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [11:0] IDENT = {3'd3, 3'd2, 3'd1, 3'd0};

    always #10 clk = ~clk;

    rx_sample_packer dut (
        .clk(clk), .rst(rst), .adc_data(adc_data), .smp_valid(smp_valid),
        .route_sel(route_sel), .dual_en(dual_en), .narrow_en(narrow_en),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // ready pattern owner: 0 low, 1 high, 2 irregular
    always @(posedge clk) begin
        #1;
        cyc++;
        case (rdy_mode)
            0:       word_ready <= 1'b0;
            1:       word_ready <= 1'b1;
            default: word_ready <= cyc[0] ^ cyc[2];
        endcase
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                checks++;
                if (!(word_valid && word_data == held_w)) begin
                    errors++;
                    $display("FAIL R6 actual %b/%h expected 1/%h", word_valid, word_data, held_w);
                end
            end
            hold_pend = word_valid && !word_ready;
            held_w    = word_data;
            if (word_valid && word_ready) begin
                if (exp_q.size() == 0) begin
                    errors++; checks++;
                    $display("FAIL R7 unexpected word actual %h expected none", word_data);
                end else begin
                    check(tag_q.pop_front(), word_data, exp_q.pop_front());
                end
            end
            if (watch && exp_q.size() > 0 && !word_valid) gaps++;
        end
    end

    function automatic logic [15:0] route(input logic [63:0] a, input logic [2:0] s);
        return (s < 3'd4) ? a[s*16 +: 16] : 16'h0000;
    endfunction

    task automatic send(input logic [63:0] a, input logic [11:0] sel,
                        input logic dual, input logic narrow, input string tag);
        logic [15:0] c [4];
        for (int g = 0; g < 4; g++) c[g] = route(a, sel[g*3 +: 3]);
        if (narrow) begin
            exp_q.push_back({c[1][15:8], c[0][15:8]}); tag_q.push_back(tag);
            if (dual) begin exp_q.push_back({c[3][15:8], c[2][15:8]}); tag_q.push_back(tag); end
        end else begin
            exp_q.push_back(c[0]); tag_q.push_back(tag);
            exp_q.push_back(c[1]); tag_q.push_back(tag);
            if (dual) begin
                exp_q.push_back(c[2]); tag_q.push_back(tag);
                exp_q.push_back(c[3]); tag_q.push_back(tag);
            end
        end
        adc_data = a; route_sel = sel; dual_en = dual; narrow_en = narrow;
        smp_valid = 1;
        step();
        smp_valid = 0;
    endtask

    task automatic drop_pulse(input logic clr);
        adc_data = 64'hDEAD_BEEF_0BAD_F00D;
        smp_valid = 1; ovr_clr = clr;
        step();
        smp_valid = 0; ovr_clr = 0;
    endtask

    task automatic drain();
        rdy_mode = 1;
        while (exp_q.size() != 0) step();
        step(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        check("R1 valid", {15'd0, word_valid}, 16'd0);
        check("R1 ovr", {15'd0, ovr_flag}, 16'd0);

        // R3 + R11
        rdy_mode = 1; step(); step();
        send(64'h4444_3333_2222_1111, IDENT, 0, 0, "R3");
        check("R11 first word valid", {15'd0, word_valid}, 16'd1);
        drain();

        // R4 with swapped routing
        send(64'hA004_B003_C002_D001, {3'd1, 3'd3, 3'd0, 3'd2}, 1, 0, "R4");
        drain();

        // R2 unconnected components
        send(64'h1234_5678_9ABC_DEF0, {3'd7, 3'd2, 3'd4, 3'd3}, 1, 0, "R2");
        drain();

        // R5 narrow single and dual
        send(64'h8899_6677_4455_2233, IDENT, 0, 1, "R5 single");
        drain();
        send(64'hF10F_E20E_D30D_C40C, {3'd0, 3'd1, 3'd3, 3'd2}, 1, 1, "R5 dual");
        drain();

        // R6 irregular ready
        rdy_mode = 2;
        for (int i = 0; i < 4; i++) begin
            send({16'(i * 97), 16'(i * 31 + 5), 16'hAB00 + 16'(i), 16'h5A5A ^ 16'(i)},
                 IDENT, 1, i[0], "R6");
            while (exp_q.size() != 0) step();
            step();
        end

        // R9 mode change while pending
        rdy_mode = 0; step(); step();
        send(64'h0F0F_1E1E_2D2D_3C3C, IDENT, 1, 0, "R9");
        narrow_en = 1; dual_en = 0;
        repeat (3) step();
        drain();

        // R10 back-to-back chaining
        rdy_mode = 1; gaps = 0; step(); step(); step();
        send(64'h1000_2000_3000_4000, IDENT, 0, 0, "R10 a");
        watch = 1;
        step();
        send(64'h1111_2222_3333_4444, IDENT, 1, 1, "R10 b");
        step();
        send(64'h5555_6666_7777_8888, IDENT, 0, 1, "R10 c");
        send(64'h9999_AAAA_BBBB_CCCC, IDENT, 1, 0, "R10 d");
        drain();
        watch = 0;
        check("R10 gaps", 16'(gaps), 16'd0);
        check("R10 no overrun", {15'd0, ovr_flag}, 16'd0);

        // R7 overrun while stalled
        rdy_mode = 0; step(); step();
        send(64'h0101_0202_0303_0404, IDENT, 0, 0, "R7 kept");
        step();
        drop_pulse(0);
        check("R7 flag set", {15'd0, ovr_flag}, 16'd1);
        repeat (4) step();
        check("R7 flag sticky", {15'd0, ovr_flag}, 16'd1);
        drain();
        check("R7 dropped group emits nothing", {15'd0, word_valid}, 16'd0);

        // R8 clear, then clear colliding with an overrun
        ovr_clr = 1; step(); ovr_clr = 0;
        check("R8 cleared", {15'd0, ovr_flag}, 16'd0);
        rdy_mode = 0; step(); step();
        send(64'h7777_6666_5555_4444, IDENT, 1, 1, "R8 kept");
        drop_pulse(1);
        check("R8 set wins over clear", {15'd0, ovr_flag}, 16'd1);
        drain();
        ovr_clr = 1; step(); ovr_clr = 0;
        check("R8 cleared again", {15'd0, ovr_flag}, 16'd0);

        check("R7 scoreboard empty", 16'(exp_q.size()), 16'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule